// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI bus master that works through a short list of transfers without help from the processor. Software stores one command word and one transmit word per list entry, tells the block which entry is the last, and sets a run bit. The block then shifts each entry out in order, starting at entry 0. Each word goes out MSB first on the serial clock and data-out lines. The word returned on the data-in line is stored in a receive memory at the same entry index. When the last entry is done, the block raises a completion flag and clears the run bit.

All three memories (command, transmit, receive) are reached through one pointer register and one data port. The pointer names a region and an entry. Each data-port access steps the pointer to the next entry, so a burst of writes fills consecutive entries. Each command entry chooses one of four chip-select lines. It also says whether that select stays active into the next entry, and whether the word width comes from the mode register or is fixed at 8 bits. Clock polarity, clock phase, the clock divider and the idle level of the selects are set once for the whole list.

Top module: `qspi_master`

## Requirements
- R1: After reset, every register reads 0, SCK is low and all four chip-select outputs are low (the idle level is 0).
- R2: Register addresses are 0 mode, 1 run, 2 wrap, 3 flag, 4 pointer and 5 data. The pointer keeps the entry index in bits 3:0 and the region in bits 5:4, with 0 transmit, 1 receive, 2 command and 3 none. Each read or write of the data port advances the entry index by one, modulo 16, within the region. A command-region read returns the 4 stored bits with zeros above them.
- R3: Data-port writes to the receive region or to region 3 change no memory. Data-port reads of region 3 return 0.
- R4: Writing 1 to run bit 0 starts the queue only if mode bit 0 (master enable) is 1. A started queue runs entries 0 up to the last index in wrap bits 3:0, in order. If master enable is 0, the write is ignored: run stays 0, no flag is raised and SCK does not toggle.
- R5: When the last entry completes, flag bit 0 becomes 1 and run bit 0 reads 0. Writing 1 to flag bit 0 clears it. Writing 0 to flag bit 0 leaves it unchanged.
- R6: Each entry shifts its word MSB first. Mode bit 1 is CPOL, the SCK idle level. Mode bit 2 is CPHA. With CPHA 0, data is sampled on the leading SCK edge. With CPHA 1, data is sampled on the trailing edge.
- R7: The word width is 8 bits unless command bit 1 is set. When command bit 1 is set, the width comes from mode bits 7:4, where 0 means 16 and any other value gives that many bits. Only the low width bits of the transmit word are sent.
- R8: Within a word, each SCK half period lasts max(B, 2) system clocks, where B is mode bits 15:8. Between words, the gap between SCK edges is never shorter than that.
- R9: Wrap bit 8 sets the idle level of all four select outputs. While an entry runs, the select line named by command bits 3:2 is driven to the inverse of the idle level. At most one select line is ever active. All select lines are idle once the queue is done.
- R10: If command bit 0 is set and the next entry names the same select line, that line stays active between the two entries. Otherwise the line returns to idle between entries, for at least one SCK half period when command bit 0 is clear.
- R11: After completion, receive entry i holds the word sampled from MISO during entry i, right-aligned, with zeros above the word width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the cycle after the strobe |
| bus_rdata | output | 16 | Registered read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select outputs, idle level set by wrap bit 8 |

## Verification
The bench drives the queue with MISO tied to the inverse of MOSI, so every receive word must be the bitwise complement of its transmit word. This catches receive-side faults that a plain loopback would hide.

Directed runs cover:
- all four polarity and phase combinations at one speed, which separates the sampling edges;
- lists with the continue bit set and clear, with repeated and changing select lines, which separate held selects from released ones;
- widths of 8, 12 and 16 bits, and divider values 0 and 9, which expose the minimum-divider clamp.

Seeded random lists mix every field, including very short mode widths and list lengths from 1 to 16. The pointer wrap, the read-only regions and the ignored start with master enable off are each checked at the register port.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

   localparam int REG_W = 16;
   localparam int NCS   = 4;
   localparam int SEL_W = $clog2(NCS);
   localparam int CMD_W = SEL_W + 2;

   localparam logic [2:0] A_MODE = 3'd0;
   localparam logic [2:0] A_RUN  = 3'd1;
   localparam logic [2:0] A_WRAP = 3'd2;
   localparam logic [2:0] A_FLAG = 3'd3;
   localparam logic [2:0] A_PTR  = 3'd4;
   localparam logic [2:0] A_DATA = 3'd5;

   typedef enum logic [1:0] {
      RG_TX   = 2'd0,
      RG_RX   = 2'd1,
      RG_CMD  = 2'd2,
      RG_NONE = 2'd3
   } region_e;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             use_mode;
      logic             hold;
   } cmd_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_LOAD  = 2'd1,
      SQ_SHIFT = 2'd2,
      SQ_GAP   = 2'd3
   } seq_state_e;

endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
   parameter int W    = 16,
   parameter int D    = 16,
   parameter int N_RD = 2,
   localparam int IW  = $clog2(D)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IW-1:0]     widx,
   input  logic [W-1:0]      wd,
   input  logic [N_RD*IW-1:0] ridx,
   output logic [N_RD*W-1:0]  rdat
);

   if (D < 2) begin : g_bad_depth
      $error("qspi_ram: depth must be at least 2");
   end
   if (N_RD < 1) begin : g_bad_ports
      $error("qspi_ram: needs at least one read port");
   end

   logic [W-1:0] mem [D];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wd;
   end

   for (genvar p = 0; p < N_RD; p++) begin : g_rd
      assign rdat[p*W +: W] = mem[ridx[p*IW +: IW]];
   end

endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
   parameter int DATA_W = 16,
   parameter int BAUD_W = 8,
   localparam int CNT_W = $clog2(DATA_W + 1),
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  bits,
   input  logic [BAUD_W-1:0] half,
   input  logic              cpha,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              miso,
   output logic              sck_i,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word
);

   logic [BAUD_W-1:0] cnt;
   logic              lead_next;
   logic [IDX_W-1:0]  bit_i;
   logic [DATA_W-1:0] txr;
   logic [DATA_W-1:0] rxr;
   logic [IDX_W-1:0]  first_i;

   assign first_i = IDX_W'(bits - 1'b1);
   assign rx_word = rxr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         lead_next <= 1'b1;
         bit_i     <= '0;
         txr       <= '0;
         rxr       <= '0;
         sck_i     <= 1'b0;
         mosi      <= 1'b0;
         busy      <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy      <= 1'b1;
               cnt       <= '0;
               lead_next <= 1'b1;
               bit_i     <= first_i;
               txr       <= tx_word;
               rxr       <= '0;
               sck_i     <= 1'b0;
               if (!cpha) mosi <= tx_word[first_i];
            end
         end else if (cnt == half - 1'b1) begin
            cnt       <= '0;
            sck_i     <= ~sck_i;
            lead_next <= ~lead_next;
            if (lead_next) begin
               if (!cpha) rxr  <= {rxr[DATA_W-2:0], miso};
               else       mosi <= txr[bit_i];
            end else begin
               if (cpha) rxr <= {rxr[DATA_W-2:0], miso};
               if (bit_i == '0) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bit_i <= bit_i - 1'b1;
                  if (!cpha) mosi <= txr[bit_i - 1'b1];
               end
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R6: with the engine stopped the raw clock rests at its idle phase
   a_r6_sck_rests: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck_i);

   // R8: every clock toggle restarts the half-period counter
   a_r8_edge_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sck_i) |-> (cnt == '0));

   // R11: a finished word leaves the engine free in the same cycle
   a_r11_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
   import qspi_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int BAUD_W = 8,
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              begin_q,
   input  logic [IW-1:0]     last_idx,
   input  logic [BAUD_W-1:0] half,
   input  cmd_t              cmd_cur,
   input  logic              sh_done,
   output logic [IW-1:0]     idx,
   output logic              sh_start,
   output logic              cs_act,
   output logic [SEL_W-1:0]  cs_sel,
   output logic              rx_we,
   output logic              finish
);

   seq_state_e        state;
   logic [BAUD_W-1:0] gcnt;

   assign sh_start = (state == SQ_LOAD);
   assign rx_we    = (state == SQ_SHIFT) && sh_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         idx    <= '0;
         gcnt   <= '0;
         cs_act <= 1'b0;
         cs_sel <= '0;
         finish <= 1'b0;
      end else begin
         finish <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (begin_q) begin
                  idx   <= '0;
                  state <= SQ_LOAD;
               end
            end
            SQ_LOAD: begin
               cs_act <= 1'b1;
               cs_sel <= cmd_cur.sel;
               state  <= SQ_SHIFT;
            end
            SQ_SHIFT: begin
               if (sh_done) begin
                  if (idx == last_idx) begin
                     cs_act <= 1'b0;
                     finish <= 1'b1;
                     state  <= SQ_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                     if (cmd_cur.hold) begin
                        state <= SQ_LOAD;
                     end else begin
                        cs_act <= 1'b0;
                        gcnt   <= '0;
                        state  <= SQ_GAP;
                     end
                  end
               end
            end
            SQ_GAP: begin
               if (gcnt == half - 1'b1) state <= SQ_LOAD;
               else                     gcnt  <= gcnt + 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R9: no select is driven while the list is not running
   a_r9_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE) |-> !cs_act);

   // R4: results are stored in strictly increasing entry order
   a_r4_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      rx_we |=> ((idx == $past(idx) + 1'b1) || (state == SQ_IDLE)));

   // R10: a held entry keeps its select through the hand-over
   a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_we && cmd_cur.hold && (idx != last_idx)) |=> cs_act);

endmodule

// File: rtl/qspi_regs.sv
module qspi_regs
   import qspi_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   parameter int BAUD_W = 8,
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              wr,
   input  logic              rd,
   output logic [REG_W-1:0]  rdata,
   input  logic              finish,
   input  logic [DATA_W-1:0] tx_q,
   input  logic [DATA_W-1:0] rx_q,
   input  logic [CMD_W-1:0]  cmd_q,
   output logic              master_en,
   output logic              cpol,
   output logic              cpha,
   output logic [3:0]        width_f,
   output logic [BAUD_W-1:0] baud,
   output logic [IW-1:0]     last_idx,
   output logic              cs_idle,
   output logic              begin_q,
   output logic              tx_we,
   output logic              cmd_we,
   output logic [IW-1:0]     bus_idx
);

   localparam logic [REG_W-1:0] MODE_MASK =
      ((REG_W'(1) << (8 + BAUD_W)) - REG_W'(1)) & ~REG_W'(8);
   localparam int IDLE_BIT = 8;

   logic [REG_W-1:0] mode_r;
   logic [IW-1:0]    last_r;
   logic             idle_r;
   logic             go_r;
   logic             flag_r;
   region_e          rg_r;
   logic [IW-1:0]    pidx_r;
   logic             hit_data;
   logic [REG_W-1:0] rd_mux;

   assign master_en = mode_r[0];
   assign cpol      = mode_r[1];
   assign cpha      = mode_r[2];
   assign width_f   = mode_r[7:4];
   assign baud      = mode_r[8 +: BAUD_W];
   assign last_idx  = last_r;
   assign cs_idle   = idle_r;
   assign bus_idx   = pidx_r;

   assign hit_data = (wr || rd) && (addr == A_DATA);
   assign begin_q  = wr && (addr == A_RUN) && wdata[0] && mode_r[0] && !go_r;
   assign tx_we    = wr && (addr == A_DATA) && (rg_r == RG_TX);
   assign cmd_we   = wr && (addr == A_DATA) && (rg_r == RG_CMD);

   always_comb begin
      rd_mux = '0;
      unique case (addr)
         A_MODE: rd_mux = mode_r;
         A_RUN:  rd_mux = REG_W'(go_r);
         A_WRAP: rd_mux = REG_W'(last_r) | (REG_W'(idle_r) << IDLE_BIT);
         A_FLAG: rd_mux = REG_W'(flag_r);
         A_PTR:  rd_mux = REG_W'({rg_r, pidx_r});
         A_DATA: begin
            unique case (rg_r)
               RG_TX:   rd_mux = REG_W'(tx_q);
               RG_RX:   rd_mux = REG_W'(rx_q);
               RG_CMD:  rd_mux = REG_W'(cmd_q);
               default: rd_mux = '0;
            endcase
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r <= '0;
         last_r <= '0;
         idle_r <= 1'b0;
         go_r   <= 1'b0;
         flag_r <= 1'b0;
         rg_r   <= RG_TX;
         pidx_r <= '0;
         rdata  <= '0;
      end else begin
         if (wr) begin
            unique case (addr)
               A_MODE: mode_r <= wdata & MODE_MASK;
               A_WRAP: begin
                  last_r <= wdata[IW-1:0];
                  idle_r <= wdata[IDLE_BIT];
               end
               A_PTR: begin
                  pidx_r <= wdata[IW-1:0];
                  rg_r   <= region_e'(wdata[IW+1:IW]);
               end
               default: ;
            endcase
         end
         if (hit_data) pidx_r <= pidx_r + 1'b1;
         if (begin_q)     go_r <= 1'b1;
         else if (finish) go_r <= 1'b0;
         if (finish)                                  flag_r <= 1'b1;
         else if (wr && (addr == A_FLAG) && wdata[0]) flag_r <= 1'b0;
         if (rd) rdata <= rd_mux;
      end
   end

   // R5: the end of the list raises the flag
   a_r5_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> flag_r);

   // R5: the end of the list drops the run bit
   a_r5_run_drops: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !go_r);

   // R4: a start request without master enable leaves the block stopped
   a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (addr == A_RUN) && !mode_r[0] && !go_r) |=> !go_r);

   // R2: every data-port access advances the entry index
   a_r2_pointer_steps: assert property (@(posedge clk) disable iff (!rst_n)
      hit_data |=> (pidx_r == $past(pidx_r) + 1'b1));

endmodule

// File: rtl/qspi_master.sv
module qspi_master
   import qspi_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   parameter int BAUD_W = 8,
   localparam int IW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   input  logic             bus_wr,
   input  logic             bus_rd,
   output logic [REG_W-1:0] bus_rdata,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic [NCS-1:0]   cs_o
);

   if (DEPTH < 2 || IW > 8) begin : g_bad_depth
      $error("qspi_master: depth must lie in 2..256");
   end
   if (DATA_W < 8 || DATA_W > 16) begin : g_bad_width
      $error("qspi_master: word width must lie in 8..16");
   end
   if (8 + BAUD_W > REG_W) begin : g_bad_baud
      $error("qspi_master: divider field does not fit the mode register");
   end

   logic              master_en, cpol, cpha, cs_idle, begin_q;
   logic              tx_we, cmd_we, finish;
   logic [3:0]        width_f;
   logic [BAUD_W-1:0] baud, half;
   logic [IW-1:0]     last_idx, bus_idx, seq_idx;
   logic [DATA_W-1:0] tx_bus, tx_eng, rx_bus, rx_word;
   logic [CMD_W-1:0]  cmd_bus, cmd_eng;
   cmd_t              cmd_cur;
   logic              sh_start, sh_done, sh_busy, sck_i;
   logic              cs_act, rx_we;
   logic [SEL_W-1:0]  cs_sel;
   logic [CNT_W-1:0]  mode_bits, bits;

   qspi_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .BAUD_W(BAUD_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
      .wr(bus_wr), .rd(bus_rd), .rdata(bus_rdata), .finish(finish),
      .tx_q(tx_bus), .rx_q(rx_bus), .cmd_q(cmd_bus),
      .master_en(master_en), .cpol(cpol), .cpha(cpha), .width_f(width_f),
      .baud(baud), .last_idx(last_idx), .cs_idle(cs_idle), .begin_q(begin_q),
      .tx_we(tx_we), .cmd_we(cmd_we), .bus_idx(bus_idx)
   );

   qspi_ram #(.W(DATA_W), .D(DEPTH), .N_RD(2)) i_tx_ram (
      .clk(clk), .we(tx_we), .widx(bus_idx), .wd(bus_wdata[DATA_W-1:0]),
      .ridx({seq_idx, bus_idx}), .rdat({tx_eng, tx_bus})
   );

   qspi_ram #(.W(CMD_W), .D(DEPTH), .N_RD(2)) i_cmd_ram (
      .clk(clk), .we(cmd_we), .widx(bus_idx), .wd(bus_wdata[CMD_W-1:0]),
      .ridx({seq_idx, bus_idx}), .rdat({cmd_eng, cmd_bus})
   );

   qspi_ram #(.W(DATA_W), .D(DEPTH), .N_RD(1)) i_rx_ram (
      .clk(clk), .we(rx_we), .widx(seq_idx), .wd(rx_word),
      .ridx(bus_idx), .rdat(rx_bus)
   );

   assign cmd_cur = cmd_t'(cmd_eng);
   assign half    = (baud < BAUD_W'(2)) ? BAUD_W'(2) : baud;

   always_comb begin
      if (width_f == 4'd0 || CNT_W'(width_f) > CNT_W'(DATA_W)) mode_bits = CNT_W'(DATA_W);
      else                                                      mode_bits = CNT_W'(width_f);
      bits = cmd_cur.use_mode ? mode_bits : CNT_W'(8);
   end

   qspi_seq #(.DEPTH(DEPTH), .BAUD_W(BAUD_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .begin_q(begin_q), .last_idx(last_idx),
      .half(half), .cmd_cur(cmd_cur), .sh_done(sh_done), .idx(seq_idx),
      .sh_start(sh_start), .cs_act(cs_act), .cs_sel(cs_sel),
      .rx_we(rx_we), .finish(finish)
   );

   qspi_shifter #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .bits(bits), .half(half),
      .cpha(cpha), .tx_word(tx_eng), .miso(miso), .sck_i(sck_i),
      .mosi(mosi), .busy(sh_busy), .done(sh_done), .rx_word(rx_word)
   );

   assign sck = sck_i ^ cpol;

   for (genvar k = 0; k < NCS; k++) begin : g_cs
      assign cs_o[k] = (cs_act && (cs_sel == SEL_W'(k))) ? ~cs_idle : cs_idle;
   end

   // R9: never more than one select away from its idle level
   a_r9_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_o ^ {NCS{cs_idle}}));

   // R4: the serial clock only moves while the engine is busy
   a_r4_clock_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_busy && !$past(sh_busy) |-> $stable(sck_i));

   // R4: no shifting starts while master enable is off
   a_r4_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
      begin_q |-> master_en);

endmodule

// File: tb/test_qspi_master.sv
module test_qspi_master;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_rdata;
   logic        sck, mosi, miso;
   logic [3:0]  cs_o;

   assign miso = ~mosi;

   qspi_master i_qspi_master (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         failures++;
         $display("FAIL R4 watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
         summary();
         $finish;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // bus access
   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   // line monitor
   bit       mon_cpol, mon_cpha, mon_idle;
   logic     prev_sck = 1'b0;
   logic [3:0] prev_cs = 4'h0;
   logic [3:0] active;
   logic     stream [256];
   int       nbits, seg_cnt, gap_min, since, edge_total, multi_sel;
   bit       have_edge, lead;

   task automatic mon_reset();
      nbits = 0; seg_cnt = 0; gap_min = 1000000; have_edge = 0;
      edge_total = 0; multi_sel = 0; since = 0;
   endtask

   always @(negedge clk) begin
      since++;
      if (rst_n) begin
         active = cs_o ^ {4{mon_idle}};
         if ($countones(active) > 1) multi_sel++;
         for (int k = 0; k < 4; k++)
            if (prev_cs[k] == mon_idle && cs_o[k] != mon_idle) seg_cnt++;
         if (sck !== prev_sck) begin
            edge_total++;
            if (have_edge && since < gap_min) gap_min = since;
            have_edge = 1;
            since = 0;
            if (active != 4'h0) begin
               lead = (sck != mon_cpol);
               if (lead != mon_cpha) begin
                  if (nbits < 256) stream[nbits] = mosi;
                  nbits++;
               end
            end
         end
      end
      prev_sck = sck;
      prev_cs  = cs_o;
   end

   // reference model
   logic [15:0] tq [16];
   logic [3:0]  cq [16];

   function automatic int wid(input logic [3:0] c, input logic [3:0] mw);
      if (!c[1]) return 8;
      return (mw == 4'd0) ? 16 : int'(mw);
   endfunction

   function automatic int exp_segs(input int n);
      int s = 1;
      for (int i = 0; i < n - 1; i++)
         if (!(cq[i][0] && cq[i][3:2] == cq[i+1][3:2])) s++;
      return s;
   endfunction

   function automatic logic [15:0] wmask(input int w);
      return (w >= 16) ? 16'hFFFF : 16'((32'd1 << w) - 1);
   endfunction

   task automatic run_queue(input int n, input bit cpol, input bit cpha,
                            input logic [3:0] mw, input logic [7:0] baud,
                            input bit idle);
      logic [15:0] v;
      int guard, p, mism, w;
      mon_cpol = cpol; mon_cpha = cpha; mon_idle = idle;
      bus_write(3'd0, {baud, mw, 1'b0, cpha, cpol, 1'b1});
      bus_write(3'd2, {7'd0, idle, 4'd0, 4'(n - 1)});
      bus_write(3'd4, 16'h0020);
      for (int i = 0; i < n; i++) bus_write(3'd5, {12'd0, cq[i]});
      bus_write(3'd4, 16'h0000);
      for (int i = 0; i < n; i++) bus_write(3'd5, tq[i]);
      bus_write(3'd3, 16'h0001);
      mon_reset();
      bus_write(3'd1, 16'h0001);
      guard = 0;
      do begin
         bus_read(3'd3, v);
         guard++;
      end while (v[0] == 1'b0 && guard < 40000);
      check("R5", "flag after list", 32'(v[0]), 1);
      bus_read(3'd1, v);
      check("R5", "run bit cleared", 32'(v), 0);
      check("R9", "selects idle after list", 32'(cs_o), 32'({4{idle}}));
      check("R9", "single active select", multi_sel, 0);
      check("R10", "select segments", seg_cnt, exp_segs(n));
      check("R8", "shortest half period", gap_min, (baud < 2) ? 2 : int'(baud));
      p = 0; mism = 0;
      for (int i = 0; i < n; i++) begin
         w = wid(cq[i], mw);
         for (int b = w - 1; b >= 0; b--) begin
            if (p < nbits && p < 256 && stream[p] !== tq[i][b]) mism++;
            p++;
         end
      end
      check("R7", "sampled bit count", nbits, p);
      check("R6", "mosi bit mismatches", mism, 0);
      bus_write(3'd4, 16'h0010);
      for (int i = 0; i < n; i++) begin
         bus_read(3'd5, v);
         check("R11", "receive entry", 32'(v), 32'(~tq[i] & wmask(wid(cq[i], mw))));
      end
   endtask

   initial begin
      logic [15:0] v;
      logic [15:0] keep;
      int n;
      void'($urandom(32'd20250611));
      mon_idle = 0; mon_cpol = 0; mon_cpha = 0;
      mon_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 5; a++) begin
         bus_read(3'(a), v);
         check("R1", "register after reset", 32'(v), 0);
      end
      check("R1", "sck after reset", 32'(sck), 0);
      check("R1", "selects after reset", 32'(cs_o), 0);

      // R2: pointer stepping and wrap within a region
      bus_write(3'd4, 16'h000E);
      bus_write(3'd5, 16'hA11A);
      bus_write(3'd5, 16'hB22B);
      bus_write(3'd5, 16'hC33C);
      bus_read(3'd4, v);
      check("R2", "pointer after wrap", 32'(v), 32'h0001);
      bus_write(3'd4, 16'h000E);
      bus_read(3'd5, v); check("R2", "tx entry 14", 32'(v), 32'hA11A);
      bus_read(3'd5, v); check("R2", "tx entry 15", 32'(v), 32'hB22B);
      bus_read(3'd5, v); check("R2", "tx entry 0", 32'(v), 32'hC33C);
      bus_write(3'd4, 16'h0025);
      bus_write(3'd5, 16'hFFFF);
      bus_write(3'd4, 16'h0025);
      bus_read(3'd5, v); check("R2", "command entry width", 32'(v), 32'h000F);

      // R4: start ignored with master enable clear
      bus_write(3'd0, 16'h0000);
      bus_write(3'd2, 16'h0003);
      mon_reset();
      bus_write(3'd1, 16'h0001);
      repeat (60) @(negedge clk);
      bus_read(3'd1, v); check("R4", "run with master off", 32'(v), 0);
      bus_read(3'd3, v); check("R4", "flag with master off", 32'(v), 0);
      check("R4", "sck edges with master off", edge_total, 0);

      // R6: all four clock modes, held selects, 8-bit words
      for (int m = 0; m < 4; m++) begin
         for (int i = 0; i < 3; i++) begin
            tq[i] = 16'h5A00 + 16'(m * 37 + i * 91);
            cq[i] = 4'b0101;
         end
         cq[2] = 4'b0100;
         run_queue(3, m[0], m[1], 4'd8, 8'd3, m[1]);
      end

      // R10: selects released between entries, changing lines, divider clamp
      for (int i = 0; i < 4; i++) begin
         tq[i] = 16'h1234 * 16'(i + 1);
         cq[i] = {2'(i), 2'b00};
      end
      cq[1] = 4'b1001;
      run_queue(4, 1'b0, 1'b0, 4'd0, 8'd0, 1'b1);

      // R7: mixed widths, 16-bit field, slow divider
      tq[0] = 16'hBEEF; cq[0] = 4'b0010;
      tq[1] = 16'hC0DE; cq[1] = 4'b0011;
      tq[2] = 16'h8001; cq[2] = 4'b0000;
      run_queue(3, 1'b1, 1'b0, 4'd0, 8'd9, 1'b0);

      // R3: receive region and region 3 are read-only
      bus_write(3'd4, 16'h0010);
      bus_read(3'd5, keep);
      bus_write(3'd4, 16'h0010);
      bus_write(3'd5, 16'h0F0F);
      bus_write(3'd4, 16'h0010);
      bus_read(3'd5, v);
      check("R3", "receive entry after write", 32'(v), 32'(keep));
      bus_write(3'd4, 16'h0030);
      bus_write(3'd5, 16'h7777);
      bus_write(3'd4, 16'h0030);
      bus_read(3'd5, v);
      check("R3", "empty region read", 32'(v), 0);

      // R5: flag write of 0 keeps it, write of 1 clears it
      bus_write(3'd3, 16'h0000);
      bus_read(3'd3, v); check("R5", "flag after writing 0", 32'(v), 1);
      bus_write(3'd3, 16'h0001);
      bus_read(3'd3, v); check("R5", "flag after writing 1", 32'(v), 0);

      // R4: full 16-entry list, 12-bit mode width
      for (int i = 0; i < 16; i++) begin
         tq[i] = 16'(16'h0F1E * (i + 3));
         cq[i] = {2'(i / 5), 1'(i % 3 != 0), 1'(i % 2)};
      end
      run_queue(16, 1'b0, 1'b1, 4'd12, 8'd2, 1'b1);

      // random lists
      for (int r = 0; r < 8; r++) begin
         n = 1 + int'($urandom % 16);
         for (int i = 0; i < 16; i++) begin
            tq[i] = 16'($urandom);
            cq[i] = 4'($urandom);
         end
         run_queue(n, 1'($urandom), 1'($urandom), 4'($urandom),
                   8'($urandom % 6), 1'($urandom));
      end

      summary();
      $finish;
   end
endmodule